// File: doc/BRIEF.md
# Dual Reloadable Down-Counter Timer

The block provides two 8-bit timer channels that count down from a programmable reload value. Each channel has its own prescaler fed by a slow or a fast source tick. When a channel passes zero it reloads, raises a sticky interrupt flag and can toggle a shared timer output. Channel 0 can also count edges on an external event input instead of prescaled ticks.

Software reaches the block through a register bus with 4-bit data and a 4-bit address. Reads are combinational and writes are strobed. A channel's counter is read through two nibble windows. Reading the low nibble captures the high nibble, so the byte comes out consistent. Run and stop requests are not applied at once. They take effect on the channel's next counting tick, which keeps the counter and its run state aligned to the counting clock.

The source ticks `slow_tick_i` and `fast_tick_i` are single-cycle enables synchronous to `clk_i`. The event input `evt_i` is assumed to be synchronised already.

Top module: `dual_timer`

## Requirements
- R1: After reset every readable register, every counter and every captured nibble reads 0, `tout_o` is 1 and `irq_o` is 0.
- R2: Control register 2 (channel 0) or 3 (channel 1) bits 3:2 set the prescaler ratio: 00 is /1, 01 is /4, 10 is /32, 11 is /256. Register 1 bit 0 (channel 0) or bit 1 (channel 1) selects the source: 0 is `slow_tick_i`, 1 is `fast_tick_i`, and the other source is ignored. A reload command restarts the prescaler, so the first counting tick follows a full ratio of source ticks.
- R3: A running counter decrements once per counting tick. A tick at count 0 reloads the value in registers 4/5 (channel 0) or 6/7 (channel 1), low nibble first, so the period is reload+1 ticks.
- R4: Writing 1 to control bit 1 copies the reload value into the counter in the next cycle. A running channel keeps counting from it, and a stopped channel holds it. Bit 1 always reads 0.
- R5: Control bit 0 is the run request. The run state follows the request only at the next counting tick. That tick decrements the counter if either the old state or the request is running. Bit 0 reads the run state, so it keeps the old value until the change applies. A channel that is stopped with no pending request ignores ticks.
- R6: Registers 8/9 (channel 0) and A/B (channel 1) return the counter's low nibble and a captured high nibble. Reading the low nibble captures the high nibble, and the captured value holds until the next low-nibble read.
- R7: Register D bit n is channel n's flag. An underflow sets it whatever the mask. Writing 1 clears it and writing 0 leaves it unchanged.
- R8: Register C bit n enables channel n's interrupt (1 = enabled). `irq_o` is 1 exactly when some flag and its enable are both 1.
- R9: Register 1 bit 3 selects the channel (0 or 1) whose underflow toggles the output state, and bit 2 enables the output. While disabled, `tout_o` is 1. While enabled, it shows the state, which inverts on each underflow of the selected channel.
- R10: Register 0 bit 1 puts channel 0 in event mode, where each edge on `evt_i` is a counting tick. Bit 0 selects the rising edge (1) or the falling edge (0). In this mode channel 0's ratio and source settings have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_tick_i | input | 1 | Slow source tick enable |
| fast_tick_i | input | 1 | Fast source tick enable |
| evt_i | input | 1 | External event level for channel 0 |
| addr_i | input | 4 | Register address |
| wdata_i | input | 4 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (drives the nibble capture) |
| rdata_o | output | 4 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt request |
| tout_o | output | 1 | Timer square-wave output |

## Verification
The hardest state to reach from the ports is the deferred run change. A run or stop request must stay pending across several bus accesses with no counting tick, and the bench then checks both the readback and the single decrement when the tick finally arrives. The stimulus holds the source ticks low while it writes and reads the control register, then releases exactly one tick. The /32 and /256 prescaler boundaries and the capture behaviour are reached the same way, by placing single ticks between register accesses. Randomly drawn reload values and tick counts then exercise long countdowns that wrap several times.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;
  localparam int NCH = 2;  // register map below is laid out for two channels
  localparam int DW  = 4;
  localparam int CW  = 2 * DW;
  localparam int PW  = 8;

  localparam logic [3:0] A_MODE  = 4'h0;
  localparam logic [3:0] A_OUT   = 4'h1;
  localparam logic [3:0] A_CTRL0 = 4'h2;
  localparam logic [3:0] A_CTRL1 = 4'h3;
  localparam logic [3:0] A_RLD0L = 4'h4;
  localparam logic [3:0] A_RLD0H = 4'h5;
  localparam logic [3:0] A_RLD1L = 4'h6;
  localparam logic [3:0] A_RLD1H = 4'h7;
  localparam logic [3:0] A_CNT0L = 4'h8;
  localparam logic [3:0] A_CNT0H = 4'h9;
  localparam logic [3:0] A_CNT1L = 4'hA;
  localparam logic [3:0] A_CNT1H = 4'hB;
  localparam logic [3:0] A_MASK  = 4'hC;
  localparam logic [3:0] A_FLAG  = 4'hD;

  function automatic logic [PW-1:0] div_limit(logic [1:0] sel);
    case (sel)
      2'b00:   return PW'(0);
      2'b01:   return PW'(3);
      2'b10:   return PW'(31);
      default: return PW'(255);
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import dual_timer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       src_tick_i,
  input  logic [1:0] div_sel_i,
  input  logic       clr_i,
  output logic       tick_o
);
  logic [PW-1:0] cnt_q;

  assign tick_o = src_tick_i && (cnt_q >= div_limit(div_sel_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (src_tick_i) cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         run_req_i,
  input  logic         load_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         run_o,
  output logic         uflow_o
);
  logic [W-1:0] cnt_q;
  logic         run_q;
  logic         active;

  // old state or request: stopping still takes one last decrement
  assign active  = run_q | run_req_i;
  assign uflow_o = tick_i && active && !load_i && (cnt_q == '0);
  assign cnt_o   = cnt_q;
  assign run_o   = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (tick_i) run_q <= run_req_i;
      if (load_i)                cnt_q <= reload_i;
      else if (tick_i && active) cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dual_timer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       slow_tick_i,
  input  logic       fast_tick_i,
  input  logic       evt_i,
  input  logic [3:0] addr_i,
  input  logic [3:0] wdata_i,
  input  logic       wr_i,
  input  logic       rd_i,
  output logic [3:0] rdata_o,
  output logic       irq_o,
  output logic       tout_o
);
  logic                    edge_rise_q, evt_mode_q, evt_q, evt_edge;
  logic [NCH-1:0]          fast_q;
  logic                    out_en_q, out_sel_q, tout_q;
  logic [NCH-1:0]          run_req_q;
  logic [NCH-1:0][1:0]     div_q;
  logic [NCH-1:0][CW-1:0]  reload_q;
  logic [NCH-1:0][CW-1:0]  cnt;
  logic [NCH-1:0][DW-1:0]  hi_cap_q;
  logic [NCH-1:0]          mask_q, flag_q;
  logic [NCH-1:0]          run_q, uflow, load, ch_tick, pre_tick;

  assign evt_edge = edge_rise_q ? (evt_i & ~evt_q) : (~evt_i & evt_q);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [3:0] CTRL_A = 4'(32'(A_CTRL0) + c);
    logic src_tick;

    assign load[c]  = wr_i && (addr_i == CTRL_A) && wdata_i[1];
    assign src_tick = fast_q[c] ? fast_tick_i : slow_tick_i;

    tmr_prescaler u_pre (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .src_tick_i(src_tick),
      .div_sel_i (div_q[c]),
      .clr_i     (load[c]),
      .tick_o    (pre_tick[c])
    );

    if (c == 0) begin : g_evt
      assign ch_tick[c] = evt_mode_q ? evt_edge : pre_tick[c];
    end else begin : g_plain
      assign ch_tick[c] = pre_tick[c];
    end

    tmr_channel #(.W(CW)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (ch_tick[c]),
      .run_req_i(run_req_q[c]),
      .load_i   (load[c]),
      .reload_i (reload_q[c]),
      .cnt_o    (cnt[c]),
      .run_o    (run_q[c]),
      .uflow_o  (uflow[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         flag_q[c] <= 1'b0;
      else if (uflow[c])                                   flag_q[c] <= 1'b1;
      else if (wr_i && addr_i == A_FLAG && wdata_i[c])     flag_q[c] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_rise_q <= 1'b0;
      evt_mode_q  <= 1'b0;
      fast_q      <= '0;
      out_en_q    <= 1'b0;
      out_sel_q   <= 1'b0;
      run_req_q   <= '0;
      div_q       <= '0;
      reload_q    <= '0;
      mask_q      <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_MODE: begin
          edge_rise_q <= wdata_i[0];
          evt_mode_q  <= wdata_i[1];
        end
        A_OUT: begin
          fast_q    <= wdata_i[1:0];
          out_en_q  <= wdata_i[2];
          out_sel_q <= wdata_i[3];
        end
        A_CTRL0, A_CTRL1: begin
          run_req_q[addr_i[0]] <= wdata_i[0];
          div_q[addr_i[0]]     <= wdata_i[3:2];
        end
        A_RLD0L, A_RLD0H, A_RLD1L, A_RLD1H: begin
          if (addr_i[0]) reload_q[addr_i[1]][CW-1:DW] <= wdata_i;
          else           reload_q[addr_i[1]][DW-1:0]  <= wdata_i;
        end
        A_MASK:  mask_q <= wdata_i[NCH-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q    <= 1'b0;
      tout_q   <= 1'b0;
      hi_cap_q <= '0;
    end else begin
      evt_q <= evt_i;
      if (uflow[out_sel_q]) tout_q <= ~tout_q;
      if (rd_i && addr_i == A_CNT0L) hi_cap_q[0] <= cnt[0][CW-1:DW];
      if (rd_i && addr_i == A_CNT1L) hi_cap_q[1] <= cnt[1][CW-1:DW];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_MODE:           rdata_o = {2'b00, evt_mode_q, edge_rise_q};
      A_OUT:            rdata_o = {out_sel_q, out_en_q, fast_q};
      A_CTRL0, A_CTRL1: rdata_o = {div_q[addr_i[0]], 1'b0, run_q[addr_i[0]]};
      A_RLD0L, A_RLD1L: rdata_o = reload_q[addr_i[1]][DW-1:0];
      A_RLD0H, A_RLD1H: rdata_o = reload_q[addr_i[1]][CW-1:DW];
      A_CNT0L:          rdata_o = cnt[0][DW-1:0];
      A_CNT0H:          rdata_o = hi_cap_q[0];
      A_CNT1L:          rdata_o = cnt[1][DW-1:0];
      A_CNT1H:          rdata_o = hi_cap_q[1];
      A_MASK:           rdata_o = {2'b00, mask_q};
      A_FLAG:           rdata_o = {2'b00, flag_q};
      default:          rdata_o = '0;
    endcase
  end

  assign irq_o  = |(flag_q & mask_q);
  assign tout_o = out_en_q ? tout_q : 1'b1;
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk
  import dual_timer_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   wr_i,
  input logic                   tout_o,
  input logic                   out_en_q,
  input logic                   out_sel_q,
  input logic [NCH-1:0]         ch_tick,
  input logic [NCH-1:0]         run_q,
  input logic [NCH-1:0]         run_req_q,
  input logic [NCH-1:0]         load,
  input logic [NCH-1:0]         uflow,
  input logic [NCH-1:0]         flag_q,
  input logic [NCH-1:0][CW-1:0] cnt,
  input logic [NCH-1:0][CW-1:0] reload_q
);
  for (genvar c = 0; c < NCH; c++) begin : g_a
    AST_UFLOW_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      uflow[c] |=> cnt[c] == $past(reload_q[c])); // R3
    AST_LOAD_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load[c] |=> cnt[c] == $past(reload_q[c])); // R4
    AST_RUN_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ch_tick[c] |=> $stable(run_q[c])); // R5
    AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_q[c] && !run_req_q[c] && !load[c]) |=> $stable(cnt[c])); // R5
    AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      uflow[c] |=> flag_q[c]); // R7
  end

  AST_TOUT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en_q && !uflow[out_sel_q] && !wr_i) |=> $stable(tout_o)); // R9
endmodule

bind dual_timer dual_timer_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (wr_i),
  .tout_o   (tout_o),
  .out_en_q (out_en_q),
  .out_sel_q(out_sel_q),
  .ch_tick  (ch_tick),
  .run_q    (run_q),
  .run_req_q(run_req_q),
  .load     (load),
  .uflow    (uflow),
  .flag_q   (flag_q),
  .cnt      (cnt),
  .reload_q (reload_q)
);

// File: tb/dual_timer_test.sv
`timescale 1ns/1ps
module dual_timer_test;
  logic       clk = 0, rst_n = 0;
  logic       slow_t = 0, fast_t = 0, evt = 0;
  logic [3:0] addr = 0, wdata = 0;
  logic       wr = 0, rd = 0;
  logic [3:0] rdata;
  logic       irq, tout;
  int         checks = 0, fails = 0;

  dual_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(slow_t), .fast_tick_i(fast_t),
    .evt_i(evt), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .irq_o(irq), .tout_o(tout)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // tasks enter and leave at a negedge
  task automatic wreg(input logic [3:0] a, input logic [3:0] d);
    addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [3:0] d);
    addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic rcnt(input int ch, output logic [7:0] v);
    logic [3:0] lo, hi;
    rreg(4'(8 + 2*ch), lo);
    rreg(4'(9 + 2*ch), hi);
    v = {hi, lo};
  endtask

  task automatic ticks(input bit fast, input int n);
    for (int i = 0; i < n; i++) begin
      if (fast) fast_t = 1; else slow_t = 1;
      @(negedge clk); fast_t = 0; slow_t = 0;
      @(negedge clk);
    end
  endtask

  task automatic evt_pulse();
    evt = 1; @(negedge clk); @(negedge clk);
    evt = 0; @(negedge clk); @(negedge clk);
  endtask

  task automatic set_reload(input int ch, input logic [7:0] r);
    wreg(4'(4 + 2*ch), r[3:0]);
    wreg(4'(5 + 2*ch), r[7:4]);
  endtask

  function automatic int exp_count(int r, int n);
    return r - (n % (r + 1));
  endfunction

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] d;
    logic [7:0] v;
    logic       t0;
    int         r, n, seed;
    seed = $urandom(32'd777);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 14; a++) begin
      rreg(4'(a), d);
      chk($sformatf("R1 addr %0h", a), d, 0);
    end
    chk("R1 tout", tout, 1);
    chk("R1 irq", irq, 0);

    // R4 load while stopped holds
    set_reload(0, 8'h25);
    wreg(4'h2, 4'b0010);
    rcnt(0, v); chk("R4 stopped load", v, 8'h25);
    ticks(0, 3);
    rcnt(0, v); chk("R5 stopped ignores ticks", v, 8'h25);

    // R5 deferred start
    wreg(4'h2, 4'b0001);
    rreg(4'h2, d); chk("R5 run reads old", d, 0);
    ticks(0, 1);
    rcnt(0, v); chk("R5 start decrement", v, 8'h24);
    rreg(4'h2, d); chk("R5 run now on", d, 1);
    ticks(0, 4);
    rcnt(0, v); chk("R3 countdown", v, 8'h20);

    // R4 load while running
    wreg(4'h2, 4'b0011);
    rcnt(0, v); chk("R4 running load", v, 8'h25);
    rreg(4'h2, d); chk("R4 cmd reads 0", d, 1);
    ticks(0, 1);
    rcnt(0, v); chk("R4 continues", v, 8'h24);

    // R5 deferred stop
    wreg(4'h2, 4'b0000);
    rreg(4'h2, d); chk("R5 stop reads old", d, 1);
    ticks(0, 1);
    rcnt(0, v); chk("R5 stop decrement", v, 8'h23);
    rreg(4'h2, d); chk("R5 stopped", d, 0);
    ticks(0, 2);
    rcnt(0, v); chk("R5 held", v, 8'h23);

    // R7 R8 underflow, flag, mask
    set_reload(0, 8'h02);
    wreg(4'h2, 4'b0011);
    ticks(0, 2);
    rreg(4'hD, d); chk("R7 no flag before", d, 0);
    ticks(0, 1);
    rcnt(0, v); chk("R3 reload on underflow", v, 8'h02);
    rreg(4'hD, d); chk("R7 flag masked set", d, 1);
    chk("R8 masked irq", irq, 0);
    wreg(4'hC, 4'b0001);
    chk("R8 irq enabled", irq, 1);
    wreg(4'hD, 4'b0000);
    rreg(4'hD, d); chk("R7 write 0 no effect", d, 1);
    wreg(4'hD, 4'b0001);
    rreg(4'hD, d); chk("R7 w1c", d, 0);
    chk("R8 irq cleared", irq, 0);
    wreg(4'hC, 4'b0000);
    wreg(4'h2, 4'b0000);
    ticks(0, 1);

    // R6 capture on channel 1
    set_reload(1, 8'h40);
    wreg(4'h3, 4'b0011);
    rreg(4'hA, d); chk("R6 lo", d, 0);
    ticks(0, 1);
    rreg(4'hB, d); chk("R6 captured hi", d, 4);
    rreg(4'hB, d); chk("R6 hi held", d, 4);
    rreg(4'hA, d); chk("R6 lo new", d, 4'hF);
    rreg(4'hB, d); chk("R6 hi new", d, 3);

    // R2 prescaler ratios
    wreg(4'h3, 4'b0000);
    ticks(0, 1);
    wreg(4'h3, 4'b0111);
    ticks(0, 3);
    rcnt(1, v); chk("R2 /4 before", v, 8'h40);
    ticks(0, 1);
    rcnt(1, v); chk("R2 /4 first", v, 8'h3F);
    ticks(0, 8);
    rcnt(1, v); chk("R2 /4 more", v, 8'h3D);
    wreg(4'h3, 4'b1011);
    ticks(0, 31);
    rcnt(1, v); chk("R2 /32 before", v, 8'h40);
    ticks(0, 1);
    rcnt(1, v); chk("R2 /32 edge", v, 8'h3F);
    wreg(4'h3, 4'b1111);
    ticks(0, 255);
    rcnt(1, v); chk("R2 /256 before", v, 8'h40);
    ticks(0, 1);
    rcnt(1, v); chk("R2 /256 edge", v, 8'h3F);
    wreg(4'h1, 4'b0010);
    wreg(4'h3, 4'b0011);
    ticks(1, 3);
    rcnt(1, v); chk("R2 fast source", v, 8'h3D);
    ticks(0, 3);
    rcnt(1, v); chk("R2 slow ignored", v, 8'h3D);
    wreg(4'h1, 4'b0000);

    // R10 event mode on channel 0
    wreg(4'h0, 4'b0011);
    set_reload(0, 8'h10);
    wreg(4'h2, 4'b0011);
    ticks(0, 5);
    rcnt(0, v); chk("R10 ticks ignored", v, 8'h10);
    evt_pulse();
    rcnt(0, v); chk("R10 rising", v, 8'h0F);
    repeat (3) evt_pulse();
    rcnt(0, v); chk("R10 rising x3", v, 8'h0C);
    wreg(4'h0, 4'b0010);
    evt = 1; @(negedge clk); @(negedge clk);
    rcnt(0, v); chk("R10 rise ignored", v, 8'h0C);
    evt = 0; @(negedge clk); @(negedge clk);
    rcnt(0, v); chk("R10 falling", v, 8'h0B);
    wreg(4'h2, 4'b1101);
    wreg(4'h1, 4'b0001);
    evt_pulse();
    rcnt(0, v); chk("R10 div/src ignored", v, 8'h0A);
    wreg(4'h0, 4'b0000);
    wreg(4'h1, 4'b0000);
    wreg(4'h2, 4'b0000);

    // R9 output on channel 1 underflow
    set_reload(1, 8'h02);
    wreg(4'h3, 4'b0011);
    chk("R9 disabled high", tout, 1);
    wreg(4'h1, 4'b1100);
    t0 = tout;
    ticks(0, 2);
    chk("R9 no toggle yet", tout, t0);
    ticks(0, 1);
    chk("R9 toggled", tout, !t0);
    ticks(0, 3);
    chk("R9 toggled back", tout, t0);
    wreg(4'h1, 4'b0000);
    chk("R9 disabled again", tout, 1);

    // R3 random countdowns on channel 1
    for (int it = 0; it < 20; it++) begin
      r = int'($urandom_range(0, 255));
      n = int'($urandom_range(0, 599));
      if (it == 0) begin r = 0; n = 5; end
      if (it == 1) begin r = 255; n = 256; end
      wreg(4'hD, 4'b0010);
      set_reload(1, 8'(r));
      wreg(4'h3, 4'b0011);
      ticks(0, n);
      rcnt(1, v); chk($sformatf("R3 r=%0d n=%0d", r, n), v, exp_count(r, n));
      rreg(4'hD, d); chk("R7 random flag", d[1], (n > r) ? 1 : 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule